// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detection

This block works out the effective address for an 8-bit processor with a 16-bit address space. A decoder gives it an addressing-mode code, the two operand bytes, the X and Y index values and the program counter, and pulses `start`. The direct modes finish in one clock. The pointer modes read two bytes from memory through a simple read port, one byte per clock, and then finish.

When the result is final, `done` pulses for one cycle. The result and its page-cross flag stay on `ea` and `page_cross` until the next operation completes. The flag tells the sequencer to add one cycle. It is raised when indexing carries into the high byte, or when a branch target lies in a different 256-byte page from the program counter.

The indirect-jump mode keeps a known pointer-wrap defect. The high pointer byte is always fetched from the same page as the low byte. A pointer at 0x10FF therefore reads 0x10FF and then 0x1000.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `busy`, `mem_rd` and `page_cross` are 0 and `ea` is 0x0000.
- R2: The mode codes are: 0 zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 indirect jump, 7 X-indexed indirect, 8 indirect Y-indexed, 9 relative. The direct modes (0–5 and 9) raise `done` in the cycle after the `start` cycle and never assert `mem_rd`.
- R3: In zero page+X and zero page+Y, `ea` is {0x00, (lo + index) mod 256} and `page_cross` is 0.
- R4: In absolute+X and absolute+Y, `ea` is ({hi,lo} + index) mod 65536. `page_cross` is 1 exactly when the high byte of the sum differs from `hi`. Modes 0 and 3 give {0x00,lo} and {hi,lo} with `page_cross` 0.
- R5: In relative mode, `ea` is `pc` plus `lo` read as a signed two's-complement byte, mod 65536. `page_cross` is 1 exactly when the high byte of `ea` differs from that of `pc`.
- R6: In indirect-jump mode, the low byte is read at P = {hi,lo} and the high byte at {hi, (lo+1) mod 256}. `ea` is {high, low} and `page_cross` is 0.
- R7: In X-indexed indirect mode, the pointer address is Z = (lo + X) mod 256. Bytes are read at {0x00,Z} and {0x00,(Z+1) mod 256}. `ea` is {high, low} and `page_cross` is 0.
- R8: In indirect Y-indexed mode, bytes are read at {0x00,lo} and {0x00,(lo+1) mod 256}, forming base B. `ea` is (B + Y) mod 65536. `page_cross` is 1 exactly when the high byte of `ea` differs from that of B.
- R9: Pointer modes (6–8) assert `mem_rd` for exactly two consecutive cycles, low byte first. `done` rises in the third cycle after the `start` cycle.
- R10: `done` is high for one cycle per operation. `ea` and `page_cross` hold their values until the next operation completes.
- R11: `start` is ignored while `busy` is 1. The running operation completes unchanged and no extra completion follows.
- R12: Mode codes 10–15 behave as absolute (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an address calculation when idle |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte (low address, zero-page address or branch offset) |
| opnd_hi | input | 8 | Second operand byte (high address) |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc | input | 16 | Program counter used by relative mode |
| mem_rdata | input | 8 | Byte returned for `mem_addr` in the same cycle |
| mem_addr | output | 16 | Pointer-fetch address |
| mem_rd | output | 1 | Pointer-fetch read strobe |
| busy | output | 1 | A pointer fetch is in progress |
| done | output | 1 | One-cycle strobe: `ea` and `page_cross` are final |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | One extra cycle is needed |

## Verification
The only hidden state is the fetch sequence and the latched pointer, low byte and Y value. A fault in any of them shows at the ports within two or three clocks of `start`.

A wrong sequence moves the `done` pulse or changes the number of `mem_rd` cycles. A wrong pointer register shows as a bad address on `mem_addr` during the fetch. A carry bug shows as a wrong high byte on `ea` or a wrong `page_cross` in the completion cycle.

The page-wrap defect is visible on the second fetch address. So the bench compares every fetch address, not only the final result.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      mode,
  input  logic [DW-1:0]   opnd_lo,
  input  logic [DW-1:0]   opnd_hi,
  input  logic [DW-1:0]   idx_x,
  input  logic [DW-1:0]   idx_y,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] mem_addr,
  output logic            mem_rd,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] ea,
  output logic            page_cross
);
  localparam int unsigned AW = 2 * DW;
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABSX = 4'd4,
                         M_ABSY = 4'd5, M_IND = 4'd6, M_INDX = 4'd7, M_INDY = 4'd8,
                         M_REL = 4'd9;
  localparam logic [DW-1:0] ZPG = '0;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;
  st_t st;

  logic [3:0]    mode_q;
  logic [DW-1:0] y_q, lo_q;
  logic [AW-1:0] ptr_q;

  wire accept = start && (st == S_IDLE);
  wire is_ptr = (mode == M_IND) || (mode == M_INDX) || (mode == M_INDY);

  wire [DW:0]   sum_x = {1'b0, opnd_lo} + {1'b0, idx_x};
  wire [DW:0]   sum_y = {1'b0, opnd_lo} + {1'b0, idx_y};
  wire [AW-1:0] rel_t = pc + {{DW{opnd_lo[DW-1]}}, opnd_lo};

  logic [AW-1:0] d_ea;
  logic          d_cross;
  always_comb begin
    d_cross = 1'b0;
    case (mode)
      M_ZP:  d_ea = {ZPG, opnd_lo};
      M_ZPX: d_ea = {ZPG, sum_x[DW-1:0]};
      M_ZPY: d_ea = {ZPG, sum_y[DW-1:0]};
      M_ABSX: begin
        d_ea    = {opnd_hi + {{(DW-1){1'b0}}, sum_x[DW]}, sum_x[DW-1:0]};
        d_cross = sum_x[DW];
      end
      M_ABSY: begin
        d_ea    = {opnd_hi + {{(DW-1){1'b0}}, sum_y[DW]}, sum_y[DW-1:0]};
        d_cross = sum_y[DW];
      end
      M_REL: begin
        d_ea    = rel_t;
        d_cross = rel_t[AW-1:DW] != pc[AW-1:DW];
      end
      default: d_ea = {opnd_hi, opnd_lo};
    endcase
  end

  logic [AW-1:0] p_start;
  always_comb begin
    case (mode)
      M_INDX:  p_start = {ZPG, sum_x[DW-1:0]};
      M_INDY:  p_start = {ZPG, opnd_lo};
      default: p_start = {opnd_hi, opnd_lo};
    endcase
  end

  wire [DW:0]   iy      = {1'b0, lo_q} + {1'b0, y_q};
  wire          use_y   = (mode_q == M_INDY);
  wire [AW-1:0] f_ea    = use_y ? {mem_rdata + {{(DW-1){1'b0}}, iy[DW]}, iy[DW-1:0]}
                                : {mem_rdata, lo_q};
  wire          f_cross = use_y && iy[DW];

  assign mem_rd   = (st != S_IDLE);
  assign busy     = mem_rd;
  assign mem_addr = (st == S_HI) ? {ptr_q[AW-1:DW], ptr_q[DW-1:0] + {{(DW-1){1'b0}}, 1'b1}}
                                 : ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= '0;
      y_q        <= '0;
      lo_q       <= '0;
      ptr_q      <= '0;
      ea         <= '0;
      page_cross <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (is_ptr) begin
            ptr_q  <= p_start;
            mode_q <= mode;
            y_q    <= idx_y;
            st     <= S_LO;
          end else begin
            ea         <= d_ea;
            page_cross <= d_cross;
            done       <= 1'b1;
          end
        end
        S_LO: begin
          lo_q <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: begin
          ea         <= f_ea;
          page_cross <= f_cross;
          done       <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_unit_props.sv
module ea_unit_props (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic [15:0] mem_addr,
  input logic        mem_rd,
  input logic        busy,
  input logic        done,
  input logic [15:0] ea,
  input logic        page_cross
);
  wire ptr_mode = (mode == 4'd6) || (mode == 4'd7) || (mode == 4'd8);

  // R2
  p_direct_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !ptr_mode |=> done && !mem_rd);
  // R3
  p_zp_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (mode == 4'd1 || mode == 4'd2) |=> ea[15:8] == 8'h00 && !page_cross);
  // R6
  p_hi_same_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr[15:8] == $past(mem_addr[15:8])
                             && mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1);
  // R9
  p_ptr_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && ptr_mode |=> mem_rd && !done);
  // R10
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(page_cross));
endmodule

bind ea_unit ea_unit_props chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .busy(busy), .done(done), .ea(ea), .page_cross(page_cross)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, ea;
  logic        mem_rd, busy, done, page_cross;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(logic [15:0] a);
    return 8'(a[7:0] * 8'd7 + a[15:8] * 8'd13 + 8'h3C);
  endfunction

  assign mem_rdata = memf(mem_addr);

  ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .busy(busy), .done(done), .ea(ea),
    .page_cross(page_cross)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input int m, lo, hi, x, y, p,
                                output int e, output int cr, output int nrd,
                                output int a0, output int a1);
    int b, l, h, z;
    cr = 0; nrd = 0; a0 = 0; a1 = 0;
    case (m)
      0: e = lo;
      1: e = (lo + x) % 256;
      2: e = (lo + y) % 256;
      4, 5: begin
        b = hi * 256 + lo;
        e = (b + ((m == 4) ? x : y)) % 65536;
        cr = ((e / 256) != hi);
      end
      6, 7, 8: begin
        nrd = 2;
        if (m == 6) begin a0 = hi * 256 + lo; a1 = hi * 256 + (lo + 1) % 256; end
        else if (m == 7) begin z = (lo + x) % 256; a0 = z; a1 = (z + 1) % 256; end
        else begin a0 = lo; a1 = (lo + 1) % 256; end
        l = memf(16'(a0)); h = memf(16'(a1));
        b = h * 256 + l;
        if (m == 8) begin e = (b + y) % 65536; cr = ((e / 256) != h); end
        else e = b;
      end
      9: begin
        e = (p + ((lo >= 128) ? lo - 256 : lo) + 65536) % 65536;
        cr = ((e / 256) != (p / 256));
      end
      default: e = hi * 256 + lo;
    endcase
  endfunction

  task automatic run(input int m, lo, hi, x, y, p, input bit poke, input string req);
    int e, cr, nrd, a0, a1, n, rd, held;
    model(m, lo, hi, x, y, p, e, cr, nrd, a0, a1);
    mode = 4'(m); opnd_lo = 8'(lo); opnd_hi = 8'(hi); idx_x = 8'(x); idx_y = 8'(y);
    pc = 16'(p); start = 1'b1;
    n = 0; rd = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) start = poke;
      else start = 1'b0;
      if (poke && n == 1) begin mode = 4'd0; opnd_lo = 8'h11; end
      if (mem_rd) begin
        if (rd == 0) chk(mem_addr == 16'(a0), req, "first fetch addr", mem_addr, a0);
        else chk(mem_addr == 16'(a1), req, "second fetch addr", mem_addr, a1);
        rd++;
      end
      if (done || n > 20) break;
    end
    chk(done, req, "done seen", done, 1);
    chk(n == ((nrd == 2) ? 3 : 1), (nrd == 2) ? "R9" : "R2", "latency", n, (nrd == 2) ? 3 : 1);
    chk(rd == nrd, (nrd == 2) ? "R9" : "R2", "read count", rd, nrd);
    chk(ea == 16'(e), req, "ea", ea, e);
    chk(page_cross == cr[0], req, "page_cross", page_cross, cr);
    held = ea;
    @(negedge clk);
    chk(!done, poke ? "R11" : "R10", "done after pulse", done, 0);
    chk(ea == 16'(held), "R10", "ea hold", ea, held);
  endtask

  function automatic string req_of(int m);
    case (m)
      0, 3: return "R4";
      1, 2: return "R3";
      4, 5: return "R4";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R5";
      default: return "R12";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_rd && !page_cross && ea == 16'h0, "R1", "reset state",
        {done, busy, mem_rd, page_cross}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(1, 8'hF0, 8'h00, 8'h20, 0, 0, 0, "R3");        // zp+X wrap
    run(2, 8'hFF, 8'h00, 0, 8'h01, 0, 0, "R3");        // zp+Y wrap
    run(4, 8'hF0, 8'h12, 8'h10, 0, 0, 0, "R4");        // exact cross
    run(5, 8'hFF, 8'hFF, 0, 8'h01, 0, 0, "R4");        // top wrap
    run(4, 8'h00, 8'h12, 8'hFF, 0, 0, 0, "R4");        // no cross
    run(6, 8'hFF, 8'h10, 0, 0, 0, 0, "R6");            // pointer page wrap
    run(7, 8'hFE, 0, 8'h01, 0, 0, 0, "R7");            // pointer at 0xFF
    run(8, 8'hFF, 0, 0, 8'hFF, 0, 0, "R8");            // zp wrap plus Y
    run(9, 8'h80, 0, 0, 0, 16'h1200, 0, "R5");         // backward cross
    run(9, 8'h10, 0, 0, 0, 16'h12F8, 0, "R5");         // forward cross
    run(9, 8'h02, 0, 0, 0, 16'h1200, 0, "R5");         // same page
    run(12, 8'h34, 8'h56, 8'h01, 8'h01, 0, 0, "R12");
    run(6, 8'h40, 8'h22, 0, 0, 0, 1, "R11");           // start while busy
    for (int i = 0; i < 300; i++) begin
      int m;
      m = int'($urandom_range(0, 15));
      run(m, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 65535)), 0, req_of(m));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule